// File: doc/BRIEF.md
# Versioned ECC Controller Register File

This block is the software-visible register file of an ECC memory controller. It holds seven 32-bit registers: enable, delay, fault status, fault address, video configuration, diagnostic and error control. Software reaches them through a plain word-addressed bus with a select, a write enable, an address, write data and combinational read data. A fault-event input from the controller core loads the fault status and fault address registers and raises an interrupt. A software write to the fault status register acknowledges that interrupt.

One controller design ships as three hardware variants, and the variant shapes the enable register. The variant input is sampled while the cold reset (`por_n`) is low and is held until the next cold reset. It decides which enable bits software may write, whether a read-only identity code sits in the top byte, and which enable bits survive a warm reset. The variant also decides whether the byte-wide diagnostic window is decoded. That window is only reported through `diag_sel`, for a diagnostic memory that lives outside this block.

All state changes on the rising clock edge. Both resets are synchronous, and the cold reset takes priority over the warm reset. Read data follows the address in the same cycle. The bus has no back-pressure: every selected access completes in the cycle it is presented.

Top module: `ecc_regfile`

## Requirements
- R1: A selected access with byte address below 0x1000 addresses the register at word index `addr >> 2`, and address bits 1:0 are ignored. The indexes are: enable 0, delay 1, fault status 2, fault address 3, video configuration 4, diagnostic 5, error control 6. `bus_rdata` returns the addressed register in the same cycle, and returns zero when `bus_sel` is low.
- R2: Word indexes 7 and above, within the register window, read as zero. A write to one of them changes no register.
- R3: On variant 0, a write to the enable register stores `wdata & 0x00000103`.
- R4: On variants 1 and 2, a write to the enable register stores `code | (wdata & 0x00000BFF)`. The codes are 0x10000000 for variant 1 and 0x20000000 for variant 2. Bits 31:24 therefore never change after cold reset. A variant input of 3 behaves exactly as variant 2.
- R5: During a cold reset the enable register loads the variant code (0 for variant 0), the delay register loads 0x20, every other register loads zero, and `irq` is low.
- R6: On a warm reset, variant 0 keeps only bit 8 of the enable register. The other variants keep only the enable bits inside mask 0xFF000BFC.
- R7: A warm reset loads the delay register with 0x20, clears fault status, video configuration and `irq`, and keeps fault address, diagnostic and error control. A warm reset overrides a write or fault event in the same cycle.
- R8: A cycle with `fault_evt` high loads fault status from `fault_status` and fault address from `fault_addr`, and `irq` is high from the next cycle.
- R9: A write to the fault status register stores all 32 bits and drives `irq` low from the next cycle. It wins over a fault event in the same cycle, for both the stored value and `irq`.
- R10: `diag_sel` is high only when the latched variant is 0, `bus_sel` is high and the address lies in 0x1000 to 0x10FF. An access in that window touches no register.
- R11: Writes to the delay, fault address, video configuration, diagnostic and error control registers store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous cold reset, active low; the variant is sampled while it is low |
| warm_rst | input | 1 | Synchronous warm reset with per-register retention |
| variant | input | 2 | Hardware variant select (0, 1, 2; 3 acts as 2) |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| fault_evt | input | 1 | Fault event from the controller core |
| fault_status | input | 32 | Status captured on a fault event |
| fault_addr | input | 32 | Address captured on a fault event |
| irq | output | 1 | Fault interrupt, level |
| diag_sel | output | 1 | Diagnostic window decode enable |

## Verification
The assertions check the following on every cycle:
- the enable register never holds a bit outside the variant 0 mask;
- the identity byte never moves on the other variants;
- a fault status write leaves `irq` low in the next cycle;
- an unopposed fault event raises `irq`;
- a warm reset leaves the delay register at 0x20;
- `diag_sel` fires only on variant 0.

The variant sweep, the warm-reset retention of each register, unmapped-address isolation and the same-cycle collision between a fault event and a software acknowledge can only be shown by the bench scenarios. The bench compares those against its reference model.

// File: rtl/ecc_regfile_pkg.sv
`timescale 1ns/1ps
package ecc_regfile_pkg;

  localparam int unsigned DW       = 32;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  localparam int unsigned IDX_ENABLE = 0;
  localparam int unsigned IDX_DELAY  = 1;
  localparam int unsigned IDX_FSTAT  = 2;
  localparam int unsigned IDX_FADDR  = 3;
  localparam int unsigned IDX_VIDCFG = 4;
  localparam int unsigned IDX_DIAG   = 5;
  localparam int unsigned IDX_ERRCTL = 6;

  localparam logic [DW-1:0] DELAY_RST   = 32'h0000_0020;
  localparam logic [DW-1:0] V0_WMASK    = 32'h0000_0103;
  localparam logic [DW-1:0] VX_WMASK    = 32'h0000_0BFF;
  localparam logic [DW-1:0] V0_KEEP     = 32'h0000_0100;
  localparam logic [DW-1:0] VX_KEEP     = 32'hFF00_0BFC;

  function automatic logic [DW-1:0] variant_code(input logic [1:0] v);
    case (v)
      2'd0:    return 32'h0000_0000;
      2'd1:    return 32'h1000_0000;
      default: return 32'h2000_0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] enable_wmask(input logic [1:0] v);
    return (v == 2'd0) ? V0_WMASK : VX_WMASK;
  endfunction

  function automatic logic [DW-1:0] enable_keep(input logic [1:0] v);
    return (v == 2'd0) ? V0_KEEP : VX_KEEP;
  endfunction

  function automatic logic [DW-1:0] cell_rst_val(input int unsigned i);
    return (i == IDX_DELAY) ? DELAY_RST : '0;
  endfunction

  function automatic bit cell_warm_load(input int unsigned i);
    return (i == IDX_DELAY) || (i == IDX_FSTAT) || (i == IDX_VIDCFG);
  endfunction

  function automatic bit cell_hw_load(input int unsigned i);
    return (i == IDX_FSTAT) || (i == IDX_FADDR);
  endfunction

endpackage

// File: rtl/ecc_reg_decode.sv
`timescale 1ns/1ps
module ecc_reg_decode #(
  parameter int unsigned AW         = 14,
  parameter int unsigned NREG       = 7,
  parameter int unsigned DIAG_BASE  = 32'h1000,
  parameter int unsigned DIAG_BYTES = 256,
  localparam int unsigned IW        = $clog2(NREG)
) (
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    var_q,
  output logic          rd_valid,
  output logic [IW-1:0] idx,
  output logic [NREG-1:0] wr_stb,
  output logic          diag_sel
);
  localparam logic [AW-1:0] BASE_A = AW'(DIAG_BASE);
  localparam logic [AW-1:0] END_A  = AW'(DIAG_BASE + DIAG_BYTES);

  logic [AW-3:0] word;
  logic          in_regwin;
  logic          mapped;

  assign word      = bus_addr[AW-1:2];
  assign in_regwin = bus_addr < BASE_A;
  assign mapped    = in_regwin && (word < (AW-2)'(NREG));
  assign idx       = word[IW-1:0];
  assign rd_valid  = bus_sel && mapped;
  assign diag_sel  = bus_sel && (var_q == 2'd0) &&
                     (bus_addr >= BASE_A) && (bus_addr < END_A);

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    assign wr_stb[g] = bus_sel && bus_we && mapped && (idx == IW'(g));
  end
endmodule

// File: rtl/ecc_reg_cell.sv
`timescale 1ns/1ps
module ecc_reg_cell #(
  parameter int unsigned   DW        = 32,
  parameter logic [DW-1:0] RST_VAL   = '0,
  parameter bit            WARM_LOAD = 1'b0
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_d,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!cold_rst_n)                q <= RST_VAL;
    else if (warm_rst) begin
      if (WARM_LOAD)                q <= RST_VAL;
    end
    else if (sw_we)                 q <= sw_d;
    else if (hw_we)                 q <= hw_d;
  end
endmodule

// File: rtl/ecc_enable_reg.sv
`timescale 1ns/1ps
module ecc_enable_reg
  import ecc_regfile_pkg::*;
(
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst,
  input  logic [1:0]    variant_in,
  input  logic [1:0]    var_q,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] wr_val;
  logic [DW-1:0] warm_val;

  assign wr_val   = variant_code(var_q) | (sw_d & enable_wmask(var_q));
  assign warm_val = q & enable_keep(var_q);

  always_ff @(posedge clk) begin
    if (!cold_rst_n)   q <= variant_code(variant_in);
    else if (warm_rst) q <= warm_val;
    else if (sw_we)    q <= wr_val;
  end
endmodule

// File: rtl/ecc_irq_ctrl.sv
`timescale 1ns/1ps
module ecc_irq_ctrl (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic warm_rst,
  input  logic fault_evt,
  input  logic ack_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!cold_rst_n || warm_rst) irq <= 1'b0;
    else if (ack_wr)             irq <= 1'b0;
    else if (fault_evt)          irq <= 1'b1;
  end
endmodule

// File: rtl/ecc_regfile.sv
`timescale 1ns/1ps
module ecc_regfile
  import ecc_regfile_pkg::*;
#(
  parameter int unsigned AW         = 14,
  parameter int unsigned DIAG_BASE  = 32'h1000,
  parameter int unsigned DIAG_BYTES = 256
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst,
  input  logic [1:0]    variant,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          fault_evt,
  input  logic [31:0]   fault_status,
  input  logic [31:0]   fault_addr,
  output logic          irq,
  output logic          diag_sel
);
  logic [1:0]          var_q;
  logic                rd_valid;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_stb;
  logic [DW-1:0]       regq [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!por_n) var_q <= variant;
  end

  ecc_reg_decode #(
    .AW(AW), .NREG(NUM_REGS), .DIAG_BASE(DIAG_BASE), .DIAG_BYTES(DIAG_BYTES)
  ) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .var_q(var_q),
    .rd_valid(rd_valid), .idx(idx), .wr_stb(wr_stb), .diag_sel(diag_sel)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == IDX_ENABLE) begin : g_en
      ecc_enable_reg u_en (
        .clk(clk), .cold_rst_n(por_n), .warm_rst(warm_rst),
        .variant_in(variant), .var_q(var_q),
        .sw_we(wr_stb[g]), .sw_d(bus_wdata), .q(regq[g])
      );
    end else begin : g_cell
      localparam bit HWL = cell_hw_load(g);
      ecc_reg_cell #(
        .DW(DW), .RST_VAL(cell_rst_val(g)), .WARM_LOAD(cell_warm_load(g))
      ) u_cell (
        .clk(clk), .cold_rst_n(por_n), .warm_rst(warm_rst),
        .sw_we(wr_stb[g]), .sw_d(bus_wdata),
        .hw_we(HWL ? fault_evt : 1'b0),
        .hw_d((g == IDX_FSTAT) ? fault_status : fault_addr),
        .q(regq[g])
      );
    end
  end

  ecc_irq_ctrl u_irq (
    .clk(clk), .cold_rst_n(por_n), .warm_rst(warm_rst),
    .fault_evt(fault_evt), .ack_wr(wr_stb[IDX_FSTAT]), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_valid && idx == IDX_W'(i)) bus_rdata = regq[i];
    end
  end
endmodule

// File: rtl/ecc_regfile_chk.sv
`timescale 1ns/1ps
module ecc_regfile_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk,
  input logic          por_n,
  input logic          warm_rst,
  input logic [1:0]    var_q,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          fault_evt,
  input logic          irq,
  input logic          diag_sel,
  input logic [31:0]   en_q,
  input logic [31:0]   dly_q
);
  logic       fstat_wr;
  logic [7:0] id_byte;

  assign fstat_wr = bus_sel && bus_we && (bus_addr[AW-1:2] == (AW-2)'(2));
  assign id_byte  = (var_q == 2'd0) ? 8'h00 : (var_q == 2'd1) ? 8'h10 : 8'h20;

  AST_EN_V0_MASK: assert property (@(posedge clk) disable iff (!por_n)
    (var_q == 2'd0) |-> ((en_q & ~32'h0000_0103) == 32'h0)); // R3
  AST_EN_ID_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (var_q != 2'd0) |-> (en_q[31:24] == id_byte)); // R4
  AST_WARM_DELAY: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> (dly_q == 32'h20)); // R7
  AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    (fault_evt && !fstat_wr && !warm_rst) |=> irq); // R8
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    fstat_wr |=> !irq); // R9
  AST_DIAG_V0_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    diag_sel |-> (var_q == 2'd0)); // R10
endmodule

bind ecc_regfile ecc_regfile_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .var_q(var_q),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .fault_evt(fault_evt), .irq(irq), .diag_sel(diag_sel),
  .en_q(regq[0]), .dly_q(regq[1])
);

// File: tb/tb_ecc_regfile.sv
`timescale 1ns/1ps
module tb_ecc_regfile;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_evt = 1'b0;
  logic [31:0] fault_status = '0;
  logic [31:0] fault_addr = '0;
  logic        irq;
  logic        diag_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_regfile dut (.*);

  // reference model
  logic [31:0] m [7];
  bit          m_irq;
  logic [1:0]  m_var;
  bit          m_live = 0;

  function automatic logic [31:0] code_of(input logic [1:0] v);
    return (v == 0) ? 32'h0 : (v == 1) ? 32'h1000_0000 : 32'h2000_0000;
  endfunction

  function automatic bit mapped(input logic [13:0] a);
    return (a < 14'h1000) && ((a >> 2) < 7);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_var = variant;
      m[0] = code_of(variant);
      m[1] = 32'h20;
      for (int i = 2; i < 7; i++) m[i] = 0;
      m_irq = 0;
    end else if (warm_rst) begin
      m[0] = m[0] & ((m_var == 0) ? 32'h100 : 32'hFF00_0BFC);
      m[1] = 32'h20; m[2] = 0; m[4] = 0; m_irq = 0;
    end else begin
      if (fault_evt) begin
        m[2] = fault_status; m[3] = fault_addr; m_irq = 1;
      end
      if (bus_sel && bus_we && mapped(bus_addr)) begin
        int k;
        k = int'(bus_addr >> 2);
        if (k == 0)
          m[0] = (m_var == 0) ? (bus_wdata & 32'h103)
                              : (code_of(m_var) | (bus_wdata & 32'hBFF));
        else m[k] = bus_wdata;
        if (k == 2) m_irq = 0;
      end
    end
    m_live = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (m_live && !done) begin
      logic [31:0] er;
      bit          ed;
      er = (bus_sel && mapped(bus_addr)) ? m[int'(bus_addr >> 2)] : 32'h0;
      ed = bus_sel && (m_var == 0) && bus_addr >= 14'h1000 && bus_addr < 14'h1100;
      chk(bus_rdata === er, "R1 model rdata", bus_rdata, er);
      chk(irq === m_irq, "R8 model irq", {31'b0, irq}, {31'b0, m_irq});
      chk(diag_sel === ed, "R10 model diag_sel", {31'b0, diag_sel}, {31'b0, ed});
    end
  end

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic cold(input logic [1:0] v);
    @(negedge clk); bus_sel = 0; por_n = 0; variant = v;
    repeat (2) @(negedge clk);
    por_n = 1;
  endtask

  task automatic warm();
    @(negedge clk); bus_sel = 0; warm_rst = 1;
    @(negedge clk); warm_rst = 0;
  endtask

  task automatic diag_probe(input logic [13:0] a, input bit e, input string tag);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = 32'hFFFF_FFFF;
    #1 chk(diag_sel === e, tag, {31'b0, diag_sel}, {31'b0, e});
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int vi = 0; vi < 4; vi++) begin
      logic [1:0]  v;
      logic [31:0] c, en_w, en_k;
      v = 2'(vi);
      c = code_of(v);
      en_w = (v == 0) ? 32'h103 : (c | 32'hBFF);
      en_k = (v == 0) ? 32'h100 : (c | 32'hBFC);
      cold(v);
      #1 chk(irq === 1'b0, "R5 irq after cold reset", {31'b0, irq}, 0);
      rd(14'h000, c, "R5 enable holds variant code");
      rd(14'h004, 32'h20, "R5 delay reset");
      for (int i = 2; i < 7; i++) rd(14'(i * 4), 32'h0, "R5 register cleared");
      rd(14'h005, 32'h20, "R1 low address bits ignored");

      wr(14'h000, 32'hFFFF_FFFF);
      if (v == 0) rd(14'h000, en_w, "R3 variant 0 enable mask");
      else        rd(14'h000, en_w, "R4 identity code kept on write");
      warm();
      rd(14'h000, en_k, "R6 warm enable retention");

      wr(14'h004, 32'hDEAD_BEEF); rd(14'h004, 32'hDEAD_BEEF, "R11 delay full width");
      wr(14'h00C, 32'h0BAD_F00D); rd(14'h00C, 32'h0BAD_F00D, "R11 fault address");
      wr(14'h010, 32'h1234_5678); rd(14'h010, 32'h1234_5678, "R11 video config");
      wr(14'h014, 32'h8765_4321); rd(14'h014, 32'h8765_4321, "R11 diagnostic");
      wr(14'h018, 32'hA5A5_5A5A); rd(14'h018, 32'hA5A5_5A5A, "R11 error control");
      warm();
      rd(14'h004, 32'h20, "R7 warm delay reload");
      rd(14'h010, 32'h0, "R7 warm video cleared");
      rd(14'h00C, 32'h0BAD_F00D, "R7 warm keeps fault address");
      rd(14'h014, 32'h8765_4321, "R7 warm keeps diagnostic");
      rd(14'h018, 32'hA5A5_5A5A, "R7 warm keeps error control");

      wr(14'h01C, 32'hFFFF_FFFF);
      rd(14'h01C, 32'h0, "R2 unmapped index reads zero");
      rd(14'h040, 32'h0, "R2 far unmapped index");
      rd(14'h000, en_k, "R2 enable untouched");
      rd(14'h018, 32'hA5A5_5A5A, "R2 error control untouched");

      @(negedge clk); bus_sel = 0; fault_evt = 1;
      fault_status = 32'hCAFE_0001; fault_addr = 32'h00AB_C000;
      @(negedge clk); fault_evt = 0;
      #1 chk(irq === 1'b1, "R8 irq raised", {31'b0, irq}, 1);
      rd(14'h008, 32'hCAFE_0001, "R8 status captured");
      rd(14'h00C, 32'h00AB_C000, "R8 address captured");
      wr(14'h008, 32'h0000_0055);
      #1 chk(irq === 1'b0, "R9 ack clears irq", {31'b0, irq}, 0);
      rd(14'h008, 32'h0000_0055, "R9 status full write");

      @(negedge clk); fault_evt = 1; fault_status = 32'h1111_2222;
      fault_addr = 32'h0000_3330;
      bus_sel = 1; bus_we = 1; bus_addr = 14'h008; bus_wdata = 32'h77;
      @(negedge clk); fault_evt = 0; bus_sel = 0; bus_we = 0;
      #1 chk(irq === 1'b0, "R9 ack wins over event", {31'b0, irq}, 0);
      rd(14'h008, 32'h77, "R9 write wins status");
      rd(14'h00C, 32'h0000_3330, "R8 address loads during ack");

      @(negedge clk); bus_sel = 0; fault_evt = 1;
      @(negedge clk); fault_evt = 0; warm_rst = 1;
      @(negedge clk); warm_rst = 0;
      #1 chk(irq === 1'b0, "R7 warm clears irq", {31'b0, irq}, 0);

      diag_probe(14'h1000, v == 0, "R10 window base");
      diag_probe(14'h10FF, v == 0, "R10 window top");
      diag_probe(14'h1100, 1'b0, "R10 past window");
      diag_probe(14'h0FFC, 1'b0, "R10 below window");
      rd(14'h000, en_k, "R10 window write leaves enable");
      rd(14'h018, 32'hA5A5_5A5A, "R10 window write leaves error control");
    end
    @(negedge clk); bus_sel = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule